// File: doc/BRIEF.md
# Multiplexed bus cycle controller

This block sequences the machine cycles that a small 8-bit processor core runs on its external bus, which has a 16-bit address space. The core hands over one request at a time (opcode fetch, memory read, memory write, I/O read, I/O write or halt), along with an address and, for writes, a data byte. The block then steps through the T-states of that cycle on the pins. It drives the high address byte on its own output-only bus. The low address byte and the data byte share one bidirectional bus, and a latch strobe tells external logic which of the two the shared bus holds at any moment.

Each cycle is described on the pins by a memory/I/O select line and two status bits. Active-low read and write strobes frame the transfer. A slow device can stretch the cycle by holding the ready input low, and the block then adds wait states. When a cycle ends, the block gives the core a one-cycle done pulse. For reads, the byte captured from the bus comes with that pulse. Tristate buffers are left to the chip level: each bus has a value output and a separate output enable, and the incoming byte arrives on its own input.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs are idle. That means `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `addr_hi_oe`=0, `done`=0, `status`=00 and `req_ready`=1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and the next cycle is T1. In T1, `ale` is high for exactly one cycle, `addr_hi` carries address bits 15..8 with `addr_hi_oe`=1, and `ad_out` carries address bits 7..0 with `ad_oe`=1.
- R3: The request code `req_kind` sets the pin encoding: 0 opcode fetch gives status 11 and io_m 0; 1 memory read gives 10 and 0; 2 memory write gives 01 and 0; 3 I/O read gives 10 and 1; 4 I/O write gives 01 and 1; 5 halt gives 00 and 0. Codes 6 and 7 act as halt. `status` is the pair {S1,S0}. Status and io_m stay constant from T1 through T3.
- R4: For codes 0, 1 and 3, `ad_oe` is low from T2 on and `rd_n` is low from T2 through T3. The byte on `ad_in` is captured at the edge where `rd_n` rises, and it appears on `rdata` with `done`.
- R5: For codes 2 and 4, `ad_out` carries the write byte with `ad_oe`=1 and `wr_n` is low, both from T2 through T3.
- R6: `ready` is sampled at the end of T2 and at the end of every wait state. Each low sample adds one wait cycle, and the strobes and buses hold their values during that cycle.
- R7: `rd_n` and `wr_n` are never low together, and neither is low during T1.
- R8: A halt cycle asserts neither strobe, leaves the shared bus released after T1, ignores `ready`, and always takes exactly T1, T2 and T3.
- R9: `req_ready` is high only when the block is idle. A `req_valid` that arrives while a cycle is running starts nothing and does not change the running cycle's pins.
- R10: `done` is a single-cycle pulse in the cycle after T3. In that cycle both buses are released and both strobes are high.
- R11: `addr_hi_oe` is high from T1 through T3 and low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle type code (see R3) |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write byte |
| req_ready | output | 1 | High when idle and able to accept a request |
| done | output | 1 | One-cycle pulse when a cycle has finished |
| rdata | output | DW | Byte captured by the last read cycle |
| ready | input | 1 | Device ready; low inserts wait states |
| addr_hi | output | AW-DW | High address byte |
| addr_hi_oe | output | 1 | Output enable of the high address bus |
| ad_out | output | DW | Value driven on the shared address/data bus |
| ad_oe | output | 1 | Output enable of the shared bus |
| ad_in | input | DW | Value read from the shared bus |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | 0 for a memory cycle, 1 for an I/O cycle |
| status | output | 2 | Cycle status {S1,S0} |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Take the accepting clock edge as edge 0. The T1 pins are then due after edge 0, the T2 pins after edge 1, and each wait state after one more edge. T3 follows one edge after the first high ready sample. The done pulse and the read byte follow one edge after T3, which is edge 3 plus the number of waits. The driver task steps through these states one falling edge at a time and checks each one. It sets ready only at the falling edge before the edge that samples it. The monitor pops the expected items from a scoreboard queue only when it sees done, so a done pulse that comes early, comes late or is missing shows up as a mismatch.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_HALT  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4
  } tstate_e;

  typedef struct packed {
    logic       is_rd;
    logic       is_wr;
    logic       is_io;
    logic       is_halt;
    logic [1:0] status;
  } cyc_attr_t;

endpackage

// File: rtl/cyc_attr_decode.sv
module cyc_attr_decode
  import bus_cyc_pkg::*;
(
  input  logic [2:0] kind,
  output cyc_attr_t  attr
);

  always_comb begin
    attr = '{is_rd: 1'b0, is_wr: 1'b0, is_io: 1'b0, is_halt: 1'b1, status: 2'b00};
    case (kind)
      K_FETCH: attr = '{is_rd: 1'b1, is_wr: 1'b0, is_io: 1'b0, is_halt: 1'b0, status: 2'b11};
      K_MRD:   attr = '{is_rd: 1'b1, is_wr: 1'b0, is_io: 1'b0, is_halt: 1'b0, status: 2'b10};
      K_MWR:   attr = '{is_rd: 1'b0, is_wr: 1'b1, is_io: 1'b0, is_halt: 1'b0, status: 2'b01};
      K_IORD:  attr = '{is_rd: 1'b1, is_wr: 1'b0, is_io: 1'b1, is_halt: 1'b0, status: 2'b10};
      K_IOWR:  attr = '{is_rd: 1'b0, is_wr: 1'b1, is_io: 1'b1, is_halt: 1'b0, status: 2'b01};
      default: ;
    endcase
  end

endmodule

// File: rtl/tstate_seq.sv
module tstate_seq
  import bus_cyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    ready,
  input  logic    skip_wait,
  output tstate_e st,
  output tstate_e st_nxt
);

  always_comb begin
    st_nxt = st;
    case (st)
      TS_IDLE: if (start) st_nxt = TS_T1;
      TS_T1:   st_nxt = TS_T2;
      TS_T2:   st_nxt = (ready || skip_wait) ? TS_T3 : TS_TW;
      TS_TW:   if (ready) st_nxt = TS_T3;
      TS_T3:   st_nxt = TS_IDLE;
      default: st_nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= TS_IDLE;
    else     st <= st_nxt;
  end

  // a wait state is only ever entered after a low ready sample
  p_wait_needs_low_r6: assert property (@(posedge clk) disable iff (rst)
    (st == TS_TW) |-> !$past(ready));

  // halt cycles never wait
  p_halt_no_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (st == TS_TW) |-> !skip_wait);

  // T3 is always followed by idle
  p_t3_ends_r10: assert property (@(posedge clk) disable iff (rst)
    (st == TS_T3) |=> (st == TS_IDLE));

endmodule

// File: rtl/bus_drive.sv
module bus_drive
  import bus_cyc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  tstate_e       st,
  input  tstate_e       st_nxt,
  input  cyc_attr_t     attr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic [HW-1:0] addr_hi,
  output logic          addr_hi_oe,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          io_m,
  output logic [1:0]    status,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done,
  output logic [DW-1:0] rdata
);

  logic nx_busy, nx_t1, nx_xfer;

  assign nx_busy = (st_nxt != TS_IDLE);
  assign nx_t1   = (st_nxt == TS_T1);
  assign nx_xfer = (st_nxt == TS_T2) || (st_nxt == TS_TW) || (st_nxt == TS_T3);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hi    <= '0;
      addr_hi_oe <= 1'b0;
      ad_out     <= '0;
      ad_oe      <= 1'b0;
      ale        <= 1'b0;
      io_m       <= 1'b0;
      status     <= 2'b00;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      done       <= 1'b0;
      rdata      <= '0;
    end else begin
      ale        <= nx_t1;
      addr_hi_oe <= nx_busy;
      addr_hi    <= addr[AW-1:DW];
      ad_oe      <= nx_t1 || (nx_xfer && attr.is_wr);
      ad_out     <= nx_t1 ? addr[DW-1:0] : wdata;
      status     <= nx_busy ? attr.status : 2'b00;
      io_m       <= nx_busy && attr.is_io;
      rd_n       <= !(nx_xfer && attr.is_rd);
      wr_n       <= !(nx_xfer && attr.is_wr);
      done       <= (st == TS_T3);
      if (st == TS_T3 && attr.is_rd) rdata <= ad_in;
    end
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_no_strobe_t1_r7: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n));

  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_status_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_hi_oe && !ale) |-> ($stable(status) && $stable(io_m)));

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (addr_hi_oe && status == 2'b00) |-> (rd_n && wr_n && (ale || !ad_oe)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_released_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ad_oe && !addr_hi_oe && rd_n && wr_n));

  p_hi_oe_span_r11: assert property (@(posedge clk) disable iff (rst)
    ale |-> addr_hi_oe);

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import bus_cyc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ready,
  output logic [HW-1:0] addr_hi,
  output logic          addr_hi_oe,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          io_m,
  output logic [1:0]    status,
  output logic          rd_n,
  output logic          wr_n
);

  tstate_e       st, st_nxt;
  cyc_attr_t     in_attr, lat_attr, cur_attr;
  logic [AW-1:0] lat_addr, cur_addr;
  logic [DW-1:0] lat_wdata, cur_wdata;
  logic          accept;

  assign req_ready = (st == TS_IDLE);
  assign accept    = req_valid && req_ready;

  cyc_attr_decode u_dec (
    .kind (req_kind),
    .attr (in_attr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_attr  <= '{is_rd: 1'b0, is_wr: 1'b0, is_io: 1'b0, is_halt: 1'b1, status: 2'b00};
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_attr  <= in_attr;
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
    end
  end

  assign cur_attr  = accept ? in_attr   : lat_attr;
  assign cur_addr  = accept ? req_addr  : lat_addr;
  assign cur_wdata = accept ? req_wdata : lat_wdata;

  tstate_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .ready     (ready),
    .skip_wait (lat_attr.is_halt),
    .st        (st),
    .st_nxt    (st_nxt)
  );

  bus_drive #(.AW(AW), .DW(DW)) u_drv (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .st_nxt     (st_nxt),
    .attr       (cur_attr),
    .addr       (cur_addr),
    .wdata      (cur_wdata),
    .ad_in      (ad_in),
    .addr_hi    (addr_hi),
    .addr_hi_oe (addr_hi_oe),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .ale        (ale),
    .io_m       (io_m),
    .status     (status),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .done       (done),
    .rdata      (rdata)
  );

  // a new address phase only starts from an accepted request while idle
  p_accept_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> $past(req_valid && req_ready));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
    addr_hi_oe |-> !req_ready);

endmodule

// File: tb/tb_mux_bus_ctrl.sv
module tb_mux_bus_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_kind = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done;
  logic [DW-1:0] rdata;
  logic          ready = 1'b1;
  logic [AW-DW-1:0] addr_hi;
  logic          addr_hi_oe, ad_oe, ale, io_m, rd_n, wr_n;
  logic [DW-1:0] ad_out, ad_in;
  logic [1:0]    status;

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  typedef struct { logic [2:0] kind; logic [AW-1:0] addr; } item_t;
  item_t sb_q[$];

  logic [DW-1:0] lat_lo = '0, lat_hi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .ready(ready), .addr_hi(addr_hi),
    .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .io_m(io_m), .status(status), .rd_n(rd_n), .wr_n(wr_n)
  );

  // device model: latches the address on the strobe, answers reads
  function automatic logic [DW-1:0] dev_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(negedge clk) if (ale) begin lat_lo <= ad_out; lat_hi <= addr_hi; end
  assign ad_in = rd_n ? 8'hEE : dev_byte({lat_hi, lat_lo});

  function automatic logic [1:0] exp_stat(input logic [2:0] k);
    case (k)
      3'd0: return 2'b11;
      3'd1, 3'd3: return 2'b10;
      3'd2, 3'd4: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction
  function automatic logic k_rd(input logic [2:0] k); return k == 0 || k == 1 || k == 3; endfunction
  function automatic logic k_wr(input logic [2:0] k); return k == 2 || k == 4; endfunction
  function automatic logic k_io(input logic [2:0] k); return k == 3 || k == 4; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard whenever a cycle finishes
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) chk("R10 unexpected done", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        if (k_rd(it.kind)) chk("R4 read data", {24'd0, rdata}, {24'd0, dev_byte(it.addr)});
      end
    end
  end

  // driver: runs one whole machine cycle and checks each T-state
  task automatic run_cycle(input logic [2:0] k, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int waits, input logic poke);
    logic strobe_rd, strobe_wr;
    strobe_rd = k_rd(k);
    strobe_wr = k_wr(k);
    @(negedge clk);
    chk("R9 ready when idle", {31'd0, req_ready}, 32'd1);
    sb_q.push_back('{kind: k, addr: a});
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    @(negedge clk); // T1
    req_valid = 1'b0;
    chk("R2 ale in T1", {31'd0, ale}, 32'd1);
    chk("R2 addr hi", {24'd0, addr_hi}, {24'd0, a[15:8]});
    chk("R2 addr lo", {24'd0, ad_out}, {24'd0, a[7:0]});
    chk("R2 ad_oe T1", {31'd0, ad_oe}, 32'd1);
    chk("R11 hi oe T1", {31'd0, addr_hi_oe}, 32'd1);
    chk("R3 status", {30'd0, status}, {30'd0, exp_stat(k)});
    chk("R3 io_m", {31'd0, io_m}, {31'd0, k_io(k)});
    chk("R7 no strobe T1", {30'd0, rd_n, wr_n}, 32'd3);
    chk("R9 busy", {31'd0, req_ready}, 32'd0);
    @(negedge clk); // T2
    chk("R2 ale low T2", {31'd0, ale}, 32'd0);
    chk("R4 rd_n T2", {31'd0, rd_n}, {31'd0, !strobe_rd});
    chk("R5 wr_n T2", {31'd0, wr_n}, {31'd0, !strobe_wr});
    chk("R4 R5 R8 ad_oe T2", {31'd0, ad_oe}, {31'd0, strobe_wr});
    if (strobe_wr) chk("R5 write byte", {24'd0, ad_out}, {24'd0, wd});
    ready = (waits == 0) && (k != 3'd5);
    if (poke) begin req_valid = 1'b1; req_kind = 3'd2; req_addr = ~a; end
    for (int w = 1; w <= waits; w++) begin
      @(negedge clk); // TW
      chk("R6 wait holds strobe", {30'd0, rd_n, wr_n}, {30'd0, !strobe_rd, !strobe_wr});
      chk("R6 wait no done", {31'd0, done}, 32'd0);
      chk("R6 wait addr", {24'd0, addr_hi}, {24'd0, a[15:8]});
      ready = (w == waits);
    end
    @(negedge clk); // T3
    chk("R6 R8 T3 no done", {31'd0, done}, 32'd0);
    chk("R4 R5 T3 strobes", {30'd0, rd_n, wr_n}, {30'd0, !strobe_rd, !strobe_wr});
    chk("R3 R9 status held", {29'd0, io_m, status}, {29'd0, k_io(k), exp_stat(k)});
    chk("R9 addr held", {24'd0, addr_hi}, {24'd0, a[15:8]});
    chk("R11 hi oe T3", {31'd0, addr_hi_oe}, 32'd1);
    req_valid = 1'b0;
    ready = 1'b1;
    @(negedge clk); // done cycle
    chk("R10 done", {31'd0, done}, 32'd1);
    chk("R10 released", {28'd0, ad_oe, addr_hi_oe, rd_n, wr_n}, 32'b0011);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
    chk("R9 R11 no extra cycle", {30'd0, ale, addr_hi_oe}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, ale, rd_n, wr_n, ad_oe, addr_hi_oe}, 32'b01100);
    chk("R1 reset status", {29'd0, done, status}, 32'd0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {27'd0, ale, rd_n, wr_n, ad_oe, addr_hi_oe}, 32'b01100);
    run_cycle(3'd0, 16'h1234, 8'h00, 0, 1'b0);
    run_cycle(3'd1, 16'hA05F, 8'h00, 2, 1'b0);
    run_cycle(3'd2, 16'h00FF, 8'hC3, 1, 1'b0);
    run_cycle(3'd3, 16'h0042, 8'h00, 0, 1'b0);
    run_cycle(3'd4, 16'h0081, 8'h5A, 3, 1'b0);
    run_cycle(3'd5, 16'hBEEF, 8'h00, 0, 1'b0);
    run_cycle(3'd1, 16'hFFFF, 8'h00, 0, 1'b1);
    run_cycle(3'd2, 16'h8000, 8'h01, 0, 1'b1);
    for (int i = 0; i < 6; i++)
      run_cycle(3'(i % 5), 16'(16'h1F0 * i + 7), 8'(i * 37), i % 3, 1'b0);
    chk("R10 scoreboard drained", sb_q.size(), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule